// File: doc/BRIEF.md
# Serial Gain-Control Word Loader

This block is the digital control front end of a programmable-gain amplifier. A host loads an 8-bit gain word over three wires: a serial clock, a serial data line and an active-low framing enable. A frame opens when the enable goes low. Each rising edge of the serial clock shifts in one data bit, most significant bit first. The frame closes when the enable goes high again. The parallel gain output keeps the old word for the whole frame and takes the new word only when a frame closes with exactly eight clock edges. A separate power-mode input is registered and drives the amplifier-enable output.

All serial inputs are asynchronous to the system clock. Each one passes through a two-flop synchroniser. Edges on the serial clock and on the enable are found by comparing each synchronised value with its value one cycle earlier, so neither wire is ever used as a clock. A frame with the wrong number of clock edges leaves the gain unchanged and sets a sticky error flag. A one-cycle strobe marks each gain update.

Top module: `gain_word_loader`

## Requirements
- R1: Bits are taken from `sdat_i` on rising edges of `sclk_i` inside a frame, most significant bit first. After a valid frame, `gain_o[7]` holds the first bit shifted and `gain_o[0]` holds the last.
- R2: A frame starts on a falling edge of `frame_n_i`. The bit count restarts at that edge, so serial clock edges seen before it do not count toward the frame.
- R3: While a frame is open, `gain_o` keeps the word from the last valid frame.
- R4: When `frame_n_i` rises after exactly 8 serial clock rising edges, `gain_o` takes the shifted word no later than 4 system clock cycles after the rise.
- R5: `gain_upd_o` is high for exactly one system cycle per valid frame, in the same cycle that `gain_o` takes the new word. It stays low for every other frame.
- R6: Serial clock edges while `frame_n_i` is high change neither `gain_o`, `gain_upd_o` nor `frame_err_o`.
- R7: A frame that closes after any number of edges other than 8 leaves `gain_o` unchanged and sets `frame_err_o`. The flag stays set until the next valid frame clears it.
- R8: `amp_en_o` follows `pwr_mode_i` (1 means forward mode with the amplifier enabled, 0 means reverse mode with it off) within 4 system cycles.
- R9: A synchronous reset (`rst` high) sets `gain_o` to `RESET_CODE` (default 8'h00). It also clears `frame_err_o`, `gain_upd_o` and `amp_en_o`, and empties the shift state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdat_i | input | 1 | Serial data, asynchronous |
| frame_n_i | input | 1 | Active-low frame enable, asynchronous |
| pwr_mode_i | input | 1 | 1 = forward (amplifier on), 0 = reverse (amplifier off) |
| gain_o | output | WORD_W | Latched gain word |
| gain_upd_o | output | 1 | One-cycle strobe when `gain_o` takes a new word |
| frame_err_o | output | 1 | Sticky flag for a frame with the wrong bit count |
| amp_en_o | output | 1 | Amplifier enable |

## Verification
Two situations are hard to reach from the ports. The first is a frame that closes with too few or too many edges right after a frame that closed correctly: the gain must stay at the earlier word while the error flag rises, and the next valid frame must clear the flag. The second is a burst of serial clocks while the frame enable is high. Random stimulus picks the bit count per frame, usually eight and sometimes anywhere from 0 to 11, and adds stray clock bursts between frames. Directed frames follow a failed frame with a valid one and check the strobe and the error flag across that change.

// File: rtl/gwl_pkg.sv
package gwl_pkg;
  // Width of a bit counter that saturates one step above n.
  function automatic int unsigned cnt_width(input int unsigned n);
    return $clog2(n + 2);
  endfunction

  // One shift step, MSB first: the new bit enters at the bottom.
  function automatic logic [31:0] shift_in(input logic [31:0] word, input logic b);
    return {word[30:0], b};
  endfunction
endpackage

// File: rtl/gwl_sync.sv
module gwl_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gwl_shifter.sv
module gwl_shifter #(
  parameter int WORD_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_n_s,
  input  logic              sclk_s,
  input  logic              sdat_s,
  output logic [WORD_W-1:0] shreg_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              active_o,
  output logic              frame_close_o
);
  import gwl_pkg::*;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WORD_W + 1);

  logic prev_frame_n, prev_sclk;
  logic frame_open, sclk_rise, shift_en;
  logic [31:0] shifted;

  assign frame_open    = prev_frame_n & ~frame_n_s;
  assign frame_close_o = ~prev_frame_n & frame_n_s & active_o;
  assign sclk_rise     = sclk_s & ~prev_sclk;
  assign shift_en      = sclk_rise & active_o & ~frame_n_s & ~frame_open;
  assign shifted       = shift_in(32'(shreg_o), sdat_s);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_frame_n <= 1'b1;
      prev_sclk    <= 1'b0;
      active_o     <= 1'b0;
      count_o      <= '0;
      shreg_o      <= '0;
    end else begin
      prev_frame_n <= frame_n_s;
      prev_sclk    <= sclk_s;
      if (frame_open) begin
        active_o <= 1'b1;
        count_o  <= '0;
      end else if (frame_close_o) begin
        active_o <= 1'b0;
      end else if (shift_en) begin
        shreg_o <= shifted[WORD_W-1:0];
        if (count_o != CNT_MAX) count_o <= count_o + 1'b1;
      end
    end
  end

  // R6: outside a frame the shift contents never move
  p_idle_no_shift_r6: assert property (@(posedge clk) disable iff (rst)
    (!active_o && !frame_open) |=> $stable(shreg_o));
  // R7: the bit counter saturates one step past a full word
  p_count_cap_r7: assert property (@(posedge clk) disable iff (rst)
    count_o <= CNT_MAX);
  // R2: a frame start always restarts the count
  p_open_restart_r2: assert property (@(posedge clk) disable iff (rst)
    frame_open |=> (count_o == '0 && active_o));
endmodule

// File: rtl/gwl_out_latch.sv
module gwl_out_latch #(
  parameter int WORD_W = 8,
  parameter int CNT_W  = 4,
  parameter logic [WORD_W-1:0] RESET_CODE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_close,
  input  logic [CNT_W-1:0]  count,
  input  logic [WORD_W-1:0] shreg,
  output logic [WORD_W-1:0] gain_o,
  output logic              gain_upd_o,
  output logic              frame_err_o
);
  logic full_word, take_word, bad_frame;

  assign full_word = (count == CNT_W'(WORD_W));
  assign take_word = frame_close & full_word;
  assign bad_frame = frame_close & ~full_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      gain_o      <= RESET_CODE;
      gain_upd_o  <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      gain_upd_o <= take_word;
      if (take_word) begin
        gain_o      <= shreg;
        frame_err_o <= 1'b0;
      end else if (bad_frame) begin
        frame_err_o <= 1'b1;
      end
    end
  end

  // R3: without a frame close the gain word holds
  p_hold_open_r3: assert property (@(posedge clk) disable iff (rst)
    !frame_close |=> $stable(gain_o));
  // R5: the update strobe lasts one cycle
  p_upd_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    gain_upd_o |=> !gain_upd_o);
  // R7: a valid update leaves the error flag clear
  p_err_clear_r7: assert property (@(posedge clk) disable iff (rst)
    gain_upd_o |-> !frame_err_o);
endmodule

// File: rtl/gain_word_loader.sv
module gain_word_loader #(
  parameter int WORD_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [WORD_W-1:0] RESET_CODE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_i,
  input  logic              sdat_i,
  input  logic              frame_n_i,
  input  logic              pwr_mode_i,
  output logic [WORD_W-1:0] gain_o,
  output logic              gain_upd_o,
  output logic              frame_err_o,
  output logic              amp_en_o
);
  import gwl_pkg::*;
  localparam int CNT_W = cnt_width(WORD_W);

  logic [3:0] raw_in, sync_in;
  logic frame_n_s, sclk_s, sdat_s, pwr_s;
  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  count;
  logic active, frame_close;

  // bit order: frame_n, sclk, sdat, pwr
  assign raw_in = {frame_n_i, sclk_i, sdat_i, pwr_mode_i};
  assign {frame_n_s, sclk_s, sdat_s, pwr_s} = sync_in;

  gwl_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1000)) sync_i (
    .clk(clk), .rst(rst), .d_i(raw_in), .q_o(sync_in));

  gwl_shifter #(.WORD_W(WORD_W), .CNT_W(CNT_W)) shifter_i (
    .clk(clk), .rst(rst), .frame_n_s(frame_n_s), .sclk_s(sclk_s),
    .sdat_s(sdat_s), .shreg_o(shreg), .count_o(count),
    .active_o(active), .frame_close_o(frame_close));

  gwl_out_latch #(.WORD_W(WORD_W), .CNT_W(CNT_W), .RESET_CODE(RESET_CODE)) latch_i (
    .clk(clk), .rst(rst), .frame_close(frame_close), .count(count),
    .shreg(shreg), .gain_o(gain_o), .gain_upd_o(gain_upd_o),
    .frame_err_o(frame_err_o));

  always_ff @(posedge clk) begin
    if (rst) amp_en_o <= 1'b0;
    else     amp_en_o <= pwr_s;
  end

  // R9: the cycle after reset shows the defined reset state
  p_reset_state_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (gain_o == RESET_CODE && !amp_en_o && !gain_upd_o && !frame_err_o));
  // R4: an update is only taken from a full word
  p_full_word_r4: assert property (@(posedge clk) disable iff (rst)
    gain_upd_o |-> ($past(count) == CNT_W'(WORD_W) && !active));
endmodule

// File: tb/gain_word_loader_tb_top.sv
module gain_word_loader_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, sdat = 1'b0, frame_n = 1'b1, pwr = 1'b0;
  logic [7:0] gain;
  logic upd, err, amp_en;
  int checks = 0, fails = 0, upd_cycles = 0;
  logic [7:0] exp_gain = 8'h00;
  logic exp_err = 1'b0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  gain_word_loader dut_i (
    .clk(clk), .rst(rst), .sclk_i(sclk), .sdat_i(sdat), .frame_n_i(frame_n),
    .pwr_mode_i(pwr), .gain_o(gain), .gain_upd_o(upd), .frame_err_o(err),
    .amp_en_o(amp_en));

  always @(posedge clk) if (upd) upd_cycles <= upd_cycles + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_sclk(input logic b);
    sdat = b; cyc(3);
    sclk = 1'b1; cyc(3);
    sclk = 1'b0;
  endtask

  // expected latch content for a frame: MSB first, exactly 8 bits
  function automatic logic [7:0] model_word(input logic [7:0] w, input int n, input logic [7:0] old);
    return (n == 8) ? w : old;
  endfunction

  task automatic send_frame(input logic [7:0] w, input int n, input string req);
    int base;
    frame_n = 1'b0; cyc(4);
    for (int i = 0; i < n; i++) pulse_sclk((i < 8) ? w[7-i] : 1'b0);
    cyc(2);
    check(gain == exp_gain, "R3 gain held mid-frame", gain, exp_gain);
    base = upd_cycles;
    frame_n = 1'b1; cyc(4);
    exp_gain = model_word(w, n, exp_gain);
    exp_err  = (n != 8);
    check(gain == exp_gain, req, gain, exp_gain);
    check(err == exp_err, "R7 error flag", err, exp_err);
    check(upd_cycles - base == ((n == 8) ? 1 : 0), "R5 strobe cycles", upd_cycles - base, (n == 8) ? 1 : 0);
    cyc(2);
  endtask

  task automatic stray_clocks(input int n);
    int base = upd_cycles;
    for (int i = 0; i < n; i++) pulse_sclk(1'($urandom));
    cyc(4);
    check(gain == exp_gain && err == exp_err && upd_cycles == base,
          "R6 stray clocks ignored", {err, gain}, {exp_err, exp_gain});
  endtask

  initial begin
    void'($urandom(32'd4242));
    cyc(3);
    rst = 1'b0; cyc(1);
    check(gain == 8'h00 && !err && !upd && !amp_en, "R9 reset state", {amp_en, err, gain}, 0);
    // R8 power mode
    pwr = 1'b1; cyc(4);
    check(amp_en == 1'b1, "R8 forward mode", amp_en, 1);
    pwr = 1'b0; cyc(4);
    check(amp_en == 1'b0, "R8 reverse mode", amp_en, 0);
    // R1 / R4 directed bit order
    send_frame(8'h80, 8, "R1 MSB first 80");
    send_frame(8'h01, 8, "R1 LSB last 01");
    send_frame(8'hA5, 8, "R4 transfer A5");
    // R7 short then long, then recovery
    send_frame(8'h3C, 7, "R7 short frame keeps gain");
    send_frame(8'hC3, 9, "R7 long frame keeps gain");
    send_frame(8'h5A, 8, "R7 valid frame clears error");
    send_frame(8'h77, 0, "R7 empty frame");
    // R6 stray clocks between frames, R2 count restarts at frame start
    stray_clocks(5);
    send_frame(8'hE1, 3, "R2 stray clocks not counted");
    stray_clocks(3);
    send_frame(8'h96, 8, "R2 frame after stray clocks");
    // random mix
    for (int k = 0; k < 40; k++) begin
      logic [7:0] w = 8'($urandom);
      int n = ($urandom % 4 == 0) ? int'($urandom % 12) : 8;
      if (k % 7 == 3) stray_clocks(2);
      send_frame(w, n, "R4 random frame");
    end
    // R9 reset mid-operation
    pwr = 1'b1; cyc(4);
    rst = 1'b1; cyc(2); rst = 1'b0; cyc(1);
    check(gain == 8'h00 && !err && !amp_en, "R9 reset after activity", {amp_en, err, gain}, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule